// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for a processor pipeline. It holds a parameterised number of page translations (64 by default). Every entry is compared against each lookup at the same time. An entry is selected only when its virtual page number matches the lookup and its 6-bit address-space tag equals the current process tag. Because of the tag, a context switch does not require the buffer to be emptied.

The three most significant address bits choose a segment:
- Two segments are translated: user space, where the top bit is 0, and kernel mapped space (`11x`).
- Two kernel segments bypass translation: `100` for cached access and `101` for uncached access. In these segments the physical address is the low 29 virtual bits with zeros above them.

The low 12 bits are the page offset and pass through unchanged. A lookup that finds no valid matching entry reports a miss. Software then loads an entry at an index it picks, through a separate refill port.

Every lookup falls into exactly one outcome class:
- `CLS_ADDR_ERR`: a user-mode access to a segment whose top bit is 1.
- `CLS_BYPASS`: a direct kernel segment.
- `CLS_MISS`: a translated segment with no valid match.
- `CLS_FAULT`: a write that matches a read-only entry.
- `CLS_HIT`: any other match.

The outcome class is decoded combinationally from the inputs and the stored entries. The only sequential behaviour is the entry store. On each clock edge the store applies the reference-bit and dirty-bit updates that a qualified `CLS_HIT` lookup requests. It also applies the refill write, and the refill write wins when both target the same entry.

Top module: `tlb_xlate`

## Requirements
- R1: Reset clears the valid flag of every entry, so any translated lookup after reset reports miss=1 and hit=0.
- R2: A lookup matching a valid entry on both virtual page number (bits 31:12) and address-space tag reports hit=1 and miss=0 in the same cycle. It also returns pa = {entry physical page, va[11:0]}.
- R3: An entry whose virtual page number matches but whose tag differs does not hit. Two entries with the same page number and different tags each translate only for their own tag.
- R4: An entry written through the refill port is used by the lookup in the next cycle. It replaces whatever that index held before.
- R5: For va[31:29]=100 the address bypasses translation: pa = {3'b000, va[28:0]}, with hit=0, miss=0 and uncached=0.
- R6: For va[31:29]=101 the address bypasses translation in the same way as R5, and uncached=1.
- R7: For va[31:30]=11 in supervisor mode (user=0) the address is translated through the entries, as it is for user space.
- R8: In user mode (user=1), any address with va[31]=1 gives addr_err=1 with hit=0, miss=0 and prot_fault=0, and changes no entry.
- R9: A write lookup that hits an entry marked read-only (writable=0) reports hit=1 and prot_fault=1. It sets neither the reference bit nor the dirty bit.
- R10: A hit without fault on a cycle with lk_req=1 sets the entry's reference bit. With lk_req=0, no entry is changed. The status outputs show the entry's bits as they were before the current cycle's update.
- R11: A permitted write hit with lk_req=1 sets the entry's dirty bit.
- R12: When several valid entries match, the lowest-indexed one supplies the result and multi_hit=1.
- R13: When a refill and a hit update target the same index at the same edge, the refilled contents are stored, with the reference bit cleared and the dirty bit as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup qualifier; allows status-bit updates |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 6 | Current address-space tag |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| wr_en | input | 1 | Refill write strobe |
| wr_idx | input | 6 | Entry index to load |
| wr_valid | input | 1 | Valid flag to load |
| wr_asid | input | 6 | Tag to load |
| wr_vpn | input | 20 | Virtual page number to load |
| wr_ppn | input | 20 | Physical page number to load |
| wr_rw | input | 1 | 1 = writable, 0 = read-only |
| wr_dirty | input | 1 | Dirty flag to load |
| pa | output | 32 | Physical address (0 on miss or address error) |
| hit | output | 1 | Valid matching entry found |
| miss | output | 1 | Translated segment with no match |
| prot_fault | output | 1 | Write to a read-only page |
| addr_err | output | 1 | User access to a kernel segment |
| uncached | output | 1 | Uncached direct segment |
| multi_hit | output | 1 | More than one entry matched |
| out_rw | output | 1 | Writable bit of the hit entry |
| out_dirty | output | 1 | Dirty bit of the hit entry |
| out_ref | output | 1 | Reference bit of the hit entry |

## Verification
The store has two write sources: the refill port, and the status update that follows a permitted hit. Both can target the same entry at the same clock edge. The bench provokes this by driving a write hit to an entry in the same cycle that the refill port rewrites that index with a clean image. It then reads the entry back in the next cycle and expects the reference and dirty bits to be 0. A lost refill, or an update that wins the collision, shows up as a 1 on those outputs.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 20;
    localparam int ASID_W = 6;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic              rw;
        logic              dirty;
        logic              refd;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        SEG_USER,
        SEG_KDIRECT,
        SEG_KNOCACHE,
        SEG_KMAPPED
    } seg_t;

    typedef enum logic [2:0] {
        CLS_ADDR_ERR,
        CLS_BYPASS,
        CLS_MISS,
        CLS_FAULT,
        CLS_HIT
    } look_cls_t;
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [2:0] top_bits,
    output seg_t       seg
);
    always_comb begin
        unique casez (top_bits)
            3'b0??:  seg = SEG_USER;
            3'b100:  seg = SEG_KDIRECT;
            3'b101:  seg = SEG_KNOCACHE;
            default: seg = SEG_KMAPPED;
        endcase
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_entry_t        ent [ENTRIES],
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic              any,
    output logic              multi,
    output logic [IDX_W-1:0]  idx
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent[g].valid && (ent[g].vpn == vpn) && (ent[g].asid == asid);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any   = |match;
    assign multi = |(match & (match - 1'b1));
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_dirty,
    output tlb_entry_t       ent [ENTRIES]
);
    tlb_entry_t mem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else begin
            if (upd_en) begin
                mem[upd_idx].refd <= 1'b1;
                if (upd_dirty) mem[upd_idx].dirty <= 1'b1;
            end
            if (wr_en) mem[wr_idx] <= wr_entry;
        end
    end

    assign ent = mem;

    // R10
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !(wr_en && wr_idx == upd_idx)) |=> mem[$past(upd_idx)].refd);

    // R13
    refill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)].refd == 1'b0) && (mem[$past(wr_idx)].vpn == $past(wr_entry.vpn)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              lk_user,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_rw,
    input  logic              wr_dirty,
    output logic [VA_W-1:0]   pa,
    output logic              hit,
    output logic              miss,
    output logic              prot_fault,
    output logic              addr_err,
    output logic              uncached,
    output logic              multi_hit,
    output logic              out_rw,
    output logic              out_dirty,
    output logic              out_ref
);
    seg_t            seg;
    look_cls_t       cls;
    tlb_entry_t      ent [ENTRIES];
    tlb_entry_t      wr_entry;
    tlb_entry_t      sel;
    logic            m_any, m_multi, upd_en;
    logic [IDX_W-1:0] m_idx;

    tlb_seg_decode u_seg (.top_bits(lk_va[VA_W-1 -: 3]), .seg(seg));

    tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ent(ent), .vpn(lk_va[VA_W-1:OFF_W]), .asid(lk_asid),
        .any(m_any), .multi(m_multi), .idx(m_idx)
    );

    always_comb begin
        wr_entry       = '0;
        wr_entry.valid = wr_valid;
        wr_entry.asid  = wr_asid;
        wr_entry.vpn   = wr_vpn;
        wr_entry.ppn   = wr_ppn;
        wr_entry.rw    = wr_rw;
        wr_entry.dirty = wr_dirty;
    end

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
        .upd_en(upd_en), .upd_idx(m_idx), .upd_dirty(lk_write),
        .ent(ent)
    );

    assign sel = ent[m_idx];

    // Outcome classification
    always_comb begin
        if (lk_user && lk_va[VA_W-1])                         cls = CLS_ADDR_ERR;
        else if (seg == SEG_KDIRECT || seg == SEG_KNOCACHE)   cls = CLS_BYPASS;
        else if (!m_any)                                      cls = CLS_MISS;
        else if (lk_write && !sel.rw)                         cls = CLS_FAULT;
        else                                                  cls = CLS_HIT;
    end

    assign upd_en = lk_req && (cls == CLS_HIT);

    // Outputs per class
    always_comb begin
        pa = '0; hit = 1'b0; miss = 1'b0; prot_fault = 1'b0; addr_err = 1'b0;
        uncached = 1'b0; multi_hit = 1'b0; out_rw = 1'b0; out_dirty = 1'b0; out_ref = 1'b0;
        unique case (cls)
            CLS_ADDR_ERR: addr_err = 1'b1;
            CLS_BYPASS: begin
                pa       = {3'b000, lk_va[VA_W-4:0]};
                uncached = (seg == SEG_KNOCACHE);
            end
            CLS_MISS: miss = 1'b1;
            CLS_FAULT, CLS_HIT: begin
                hit        = 1'b1;
                prot_fault = (cls == CLS_FAULT);
                pa         = {sel.ppn, lk_va[OFF_W-1:0]};
                multi_hit  = m_multi;
                out_rw     = sel.rw;
                out_dirty  = sel.dirty;
                out_ref    = sel.refd;
            end
            default: ;
        endcase
    end

    // R2
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    // R8
    addr_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!hit && !miss && !prot_fault && lk_user));

    // R9
    fault_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (hit && lk_write && !out_rw));

    // R6
    uncached_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uncached |-> (!hit && !miss && pa[VA_W-1 -: 3] == 3'b000));

    // R12
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> hit);
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
    logic [31:0] lk_va = '0;
    logic [5:0]  lk_asid = '0;
    logic        wr_en = 1'b0, wr_valid = 1'b0, wr_rw = 1'b0, wr_dirty = 1'b0;
    logic [5:0]  wr_idx = '0, wr_asid = '0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic [31:0] pa;
    logic hit, miss, prot_fault, addr_err, uncached, multi_hit, out_rw, out_dirty, out_ref;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_write(lk_write), .lk_user(lk_user), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_asid(wr_asid), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_rw(wr_rw), .wr_dirty(wr_dirty), .pa(pa), .hit(hit), .miss(miss),
        .prot_fault(prot_fault), .addr_err(addr_err), .uncached(uncached),
        .multi_hit(multi_hit), .out_rw(out_rw), .out_dirty(out_dirty), .out_ref(out_ref)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_refill(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                              input logic [19:0] ppn, input logic rw, input logic dirty, input logic v);
        wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn;
        wr_rw = rw; wr_dirty = dirty; wr_valid = v; wr_en = 1'b1;
    endtask

    task automatic refill(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                          input logic [19:0] ppn, input logic rw, input logic dirty, input logic v);
        @(negedge clk);
        lk_req = 1'b0;
        set_refill(idx, vpn, asid, ppn, rw, dirty, v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic wr,
                        input logic usr, input logic req = 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        lk_va = va; lk_asid = asid; lk_write = wr; lk_user = usr; lk_req = req;
        #1;
    endtask

    task automatic t_reset;
        look(32'h0000_1000, 6'd1, 1'b0, 1'b1);
        check("R1 miss after reset", {31'b0, miss}, 32'd1);
        check("R1 no hit after reset", {31'b0, hit}, 32'd0);
    endtask

    task automatic t_basic;
        refill(6'd5, 20'h00012, 6'd3, 20'hABCDE, 1'b1, 1'b0, 1'b1);
        look(32'h0001_2345, 6'd3, 1'b0, 1'b1);
        check("R2 hit", {31'b0, hit}, 32'd1);
        check("R2 pa", pa, 32'hABCD_E345);
        check("R4 refill visible", {31'b0, miss}, 32'd0);
        check("R10 ref before update", {31'b0, out_ref}, 32'd0);
        look(32'h0001_2345, 6'd3, 1'b0, 1'b1);
        check("R10 ref after hit", {31'b0, out_ref}, 32'd1);
        look(32'h0001_2345, 6'd4, 1'b0, 1'b1);
        check("R3 tag mismatch misses", {31'b0, miss}, 32'd1);
    endtask

    task automatic t_asid_pair;
        refill(6'd9, 20'h00012, 6'd4, 20'h11111, 1'b1, 1'b0, 1'b1);
        look(32'h0001_2345, 6'd4, 1'b0, 1'b1);
        check("R3 tag 4 pa", pa, 32'h1111_1345);
        look(32'h0001_2345, 6'd3, 1'b0, 1'b1);
        check("R3 tag 3 pa", pa, 32'hABCD_E345);
    endtask

    task automatic t_dirty;
        look(32'h0001_2000, 6'd3, 1'b1, 1'b1);
        check("R11 write hit no fault", {30'b0, hit, prot_fault}, 32'd2);
        check("R11 dirty before", {31'b0, out_dirty}, 32'd0);
        look(32'h0001_2000, 6'd3, 1'b0, 1'b1);
        check("R11 dirty after", {31'b0, out_dirty}, 32'd1);
    endtask

    task automatic t_protect;
        refill(6'd20, 20'h00030, 6'd3, 20'h22222, 1'b0, 1'b0, 1'b1);
        look(32'h0003_0010, 6'd3, 1'b1, 1'b1);
        check("R9 fault", {30'b0, hit, prot_fault}, 32'd3);
        look(32'h0003_0010, 6'd3, 1'b0, 1'b1);
        check("R9 no dirty", {31'b0, out_dirty}, 32'd0);
        check("R9 no ref", {31'b0, out_ref}, 32'd0);
        check("R9 read ok", {31'b0, prot_fault}, 32'd0);
    endtask

    task automatic t_overwrite;
        refill(6'd20, 20'h00031, 6'd3, 20'h33333, 1'b1, 1'b0, 1'b1);
        look(32'h0003_0010, 6'd3, 1'b0, 1'b1);
        check("R4 old mapping gone", {31'b0, miss}, 32'd1);
        look(32'h0003_1010, 6'd3, 1'b0, 1'b1);
        check("R4 new mapping", pa, 32'h3333_3010);
    endtask

    task automatic t_bypass;
        look(32'h8123_4567, 6'd0, 1'b0, 1'b0);
        check("R5 pa", pa, 32'h0123_4567);
        check("R5 flags", {28'b0, hit, miss, uncached, addr_err}, 32'd0);
        look(32'hA123_4567, 6'd0, 1'b1, 1'b0);
        check("R6 pa", pa, 32'h0123_4567);
        check("R6 flags", {28'b0, hit, miss, uncached, addr_err}, 32'd2);
    endtask

    task automatic t_kmapped;
        refill(6'd33, 20'hC0005, 6'd7, 20'h00077, 1'b1, 1'b0, 1'b1);
        look(32'hC000_5ABC, 6'd7, 1'b1, 1'b1);
        check("R8 user kernel access", {28'b0, addr_err, hit, miss, prot_fault}, 32'd8);
        look(32'h8000_0000, 6'd7, 1'b0, 1'b1);
        check("R8 user direct segment", {31'b0, addr_err}, 32'd1);
        look(32'hC000_5ABC, 6'd7, 1'b0, 1'b0);
        check("R7 kernel mapped pa", pa, 32'h0007_7ABC);
        check("R8 no state change", {30'b0, out_ref, out_dirty}, 32'd0);
    endtask

    task automatic t_multi;
        refill(6'd50, 20'h00050, 6'd1, 20'h00500, 1'b1, 1'b0, 1'b1);
        refill(6'd45, 20'h00050, 6'd1, 20'h00450, 1'b1, 1'b0, 1'b1);
        look(32'h0005_0123, 6'd1, 1'b0, 1'b1);
        check("R12 lowest index", pa, 32'h0045_0123);
        check("R12 multi flag", {31'b0, multi_hit}, 32'd1);
        refill(6'd45, 20'h00050, 6'd1, 20'h00450, 1'b1, 1'b0, 1'b0);
        look(32'h0005_0123, 6'd1, 1'b0, 1'b1);
        check("R12 single after invalidate", {31'b0, multi_hit}, 32'd0);
        check("R12 remaining entry", pa, 32'h0050_0123);
    endtask

    task automatic t_noreq;
        refill(6'd61, 20'h00071, 6'd2, 20'h00610, 1'b1, 1'b0, 1'b1);
        look(32'h0007_1000, 6'd2, 1'b1, 1'b1, 1'b0);
        look(32'h0007_1000, 6'd2, 1'b0, 1'b1);
        check("R10 lk_req=0 leaves bits", {30'b0, out_ref, out_dirty}, 32'd0);
    endtask

    task automatic t_collide;
        refill(6'd60, 20'h00070, 6'd2, 20'h00600, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        lk_va = 32'h0007_0004; lk_asid = 6'd2; lk_write = 1'b1; lk_user = 1'b1; lk_req = 1'b1;
        set_refill(6'd60, 20'h00070, 6'd2, 20'h00601, 1'b1, 1'b0, 1'b1);
        #1;
        check("R13 write hit in collision cycle", {31'b0, hit}, 32'd1);
        look(32'h0007_0004, 6'd2, 1'b0, 1'b1);
        check("R13 refilled ppn", pa, 32'h0060_1004);
        check("R13 refill wins", {30'b0, out_ref, out_dirty}, 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_asid_pair();
        t_dirty();
        t_protect();
        t_overwrite();
        t_bypass();
        t_kmapped();
        t_multi();
        t_noreq();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule